// File: doc/BRIEF.md
# Indirect Interrupt Redirection Controller

This block turns up to `NPIN` interrupt input levels into interrupt delivery messages for a set of `NCPU` processors. Each input owns a 64-bit redirection entry that holds its vector, its mask, its trigger mode, its delivery and destination modes, and its destination ID. Software reaches every internal register through two 32-bit bus locations. A select register at byte offset 0x00 picks an internal register index. A data window at byte offset 0x10 reads or writes the register that the select value names.

An input is evaluated only when its level changes. When an input goes from low to high and its entry is unmasked, uses physical destination and uses fixed delivery, the block emits a one-cycle delivery pulse. The pulse carries the entry's vector and a per-CPU destination mask.

When a level-triggered input rises while its entry is masked, the request is held as pending. If a later table write unmasks the entry and the input is still high, the request is delivered; if the input has fallen by then, the request is dropped. When several inputs need delivery at the same time, they are serialised one per cycle, lowest input first.

Top module: `irq_redir_ctrl`

## Requirements
- R1: A bus access is honoured only when `bus_size` is 4 and `bus_addr` is 0x00 or 0x10. Any other access returns zero read data and changes no state.
- R2: The select register at offset 0x00 stores all 32 written bits and reads them back. Accesses through the window at offset 0x10 use select bits 7:0 as the internal index.
- R3: Internal index 0x00 is the identity register: a write keeps only data bits 31:24 and reads return those bits in place. Index 0x02 always reads the same value as index 0x00. Index 0x01 reads `(NPIN << 16) | 0x11` (0x00100011 by default). Writes to indexes 0x01 and 0x02 change nothing.
- R4: Index 0x10+2p reads and writes bits 31:0 of entry p, and index 0x11+2p reads and writes bits 63:32. A write replaces only the addressed half. Every index outside 0x00..0x02 and the table reads zero.
- R5: After reset, select and identity read zero, every entry reads 0x0001000000010000 (both halves 0x00010000), and no delivery occurs.
- R6: A low-to-high change of input p, with entry p having bit 16 (mask) = 0, bit 11 (destination mode) = 0 and bits 10:8 (delivery mode) = 000, produces exactly one `dlv_valid` pulse. The pulse appears on the second rising clock edge after the input change is sampled and carries `dlv_vector` = entry bits 7:0. Holding the input high, driving the same level again, or dropping it produces no delivery.
- R7: The destination ID is entry bits 63:56. ID 0xFF gives `dlv_dest` = `cpu_active`. An ID below NCPU gives a one-hot mask with bit ID set. An ID of NCPU or above, or a broadcast with no active CPU, gives no pulse.
- R8: A rising input whose entry is masked with bit 15 (trigger) = 0 (edge) is discarded. Unmasking the entry afterwards delivers nothing.
- R9: A rising input whose entry is masked with bit 15 = 1 (level) becomes pending. A later table write that leaves the entry unmasked clears the pending state. If the input is high at that write, the message is delivered with the same latency as R6; otherwise nothing is delivered. A second unmask delivers nothing more.
- R10: A rising input whose entry has delivery mode other than 000, or destination mode 1, produces no delivery.
- R11: Deliveries that become due in the same cycle leave on consecutive cycles, lowest input index first, and none is lost.
- R12: When a table write and an input rise happen in the same cycle, the rise is evaluated against the entry as updated by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq_in | input | NPIN | Interrupt input levels, synchronous to clk |
| cpu_active | input | NCPU | Processors that receive broadcasts |
| dlv_valid | output | 1 | One-cycle delivery strobe |
| dlv_vector | output | 8 | Vector of the delivery |
| dlv_dest | output | NCPU | Destination processor mask of the delivery |

## Verification
The assertions take for granted that `irq_in` and `cpu_active` are already synchronous to `clk`. They also assume a bus access finishes in the cycle it is presented, so read data is judged in that same cycle. The stimulus drives every input on the falling clock edge and holds each access for exactly one cycle. It changes `cpu_active` only while no delivery is waiting, so the mask seen at grant time is the one the bench expects.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int unsigned ENT_W     = 64;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IDX_W     = 8;
  localparam logic [7:0]  OFS_SEL   = 8'h00;
  localparam logic [7:0]  OFS_WIN   = 8'h10;
  localparam logic [2:0]  ACC_BYTES = 3'd4;
  localparam logic [7:0]  IDX_ID    = 8'h00;
  localparam logic [7:0]  IDX_VER   = 8'h01;
  localparam logic [7:0]  IDX_ARB   = 8'h02;
  localparam int unsigned IDX_TBL   = 16;
  localparam logic [7:0]  VER_LOW   = 8'h11;
  localparam int unsigned ID_LSB    = 24;
  localparam int unsigned ID_W      = 8;
  localparam int unsigned BIT_MASK  = 16;
  localparam int unsigned BIT_TRIG  = 15;
  localparam int unsigned BIT_DSTM  = 11;
  localparam int unsigned DLV_LSB   = 8;
  localparam int unsigned DLV_W     = 3;
  localparam logic [2:0]  DLV_FIXED = 3'b000;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned DID_LSB   = 56;
  localparam int unsigned DID_W     = 8;
  localparam logic [7:0]  DID_ALL   = 8'hFF;
  localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;
endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic                        clk,
  input  logic                        arst_n,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [7:0]                  bus_addr,
  input  logic [2:0]                  bus_size,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic [WORD_W-1:0]           sel_q,
  output logic [NPIN-1:0][ENT_W-1:0]  tbl_q,
  output logic [NPIN-1:0][ENT_W-1:0]  tbl_nx,
  output logic [NPIN-1:0]             tbl_wr
);
  localparam logic [WORD_W-1:0] VER_VAL = (WORD_W'(NPIN) << 16) | WORD_W'(VER_LOW);

  logic             acc_ok, wr_sel, wr_win, rd_acc;
  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  id_q, id_d;
  logic             id_en;
  logic [WORD_W-1:0] win_val;

  always_comb begin
    acc_ok = bus_req && (bus_size == ACC_BYTES) &&
             ((bus_addr == OFS_SEL) || (bus_addr == OFS_WIN));
    wr_sel = acc_ok && bus_we && (bus_addr == OFS_SEL);
    wr_win = acc_ok && bus_we && (bus_addr == OFS_WIN);
    rd_acc = acc_ok && !bus_we;
    idx    = sel_q[IDX_W-1:0];
    id_en  = wr_win && (idx == IDX_ID);
    id_d   = bus_wdata[ID_LSB +: ID_W];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sel_q <= '0;
    end else if (wr_sel) begin
      sel_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      id_q <= '0;
    end else if (id_en) begin
      id_q <= id_d;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_ent
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(IDX_TBL + 2 * p);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(IDX_TBL + 2 * p + 1);
    logic hit_lo, hit_hi;

    always_comb begin
      hit_lo    = wr_win && (idx == LO_IDX);
      hit_hi    = wr_win && (idx == HI_IDX);
      tbl_wr[p] = hit_lo || hit_hi;
      tbl_nx[p] = tbl_q[p];
      if (hit_lo) tbl_nx[p][WORD_W-1:0]     = bus_wdata;
      if (hit_hi) tbl_nx[p][ENT_W-1:WORD_W] = bus_wdata;
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        tbl_q[p] <= ENTRY_RST;
      end else if (tbl_wr[p]) begin
        tbl_q[p] <= tbl_nx[p];
      end
    end
  end

  always_comb begin
    win_val = '0;
    if ((idx == IDX_ID) || (idx == IDX_ARB)) begin
      win_val = WORD_W'(id_q) << ID_LSB;
    end else if (idx == IDX_VER) begin
      win_val = VER_VAL;
    end
    for (int p = 0; p < NPIN; p++) begin
      if (idx == IDX_W'(IDX_TBL + 2 * p))     win_val = tbl_q[p][WORD_W-1:0];
      if (idx == IDX_W'(IDX_TBL + 2 * p + 1)) win_val = tbl_q[p][ENT_W-1:WORD_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      bus_rdata = (bus_addr == OFS_SEL) ? sel_q : win_val;
    end
  end
endmodule

// File: rtl/irq_redir_pin.sv
module irq_redir_pin
  import irq_redir_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             irq,
  input  logic [ENT_W-1:0] entry_nx,
  input  logic             tbl_wr,
  input  logic             grant,
  output logic             fire_q,
  output logic             pend_q,
  output logic             lvl_q
);
  logic masked, level, ok, rise, replay;
  logic fire_d, pend_d;
  logic lvl_en, pend_en, fire_en;
  logic unused_fields;

  assign unused_fields = ^{entry_nx[ENT_W-1:BIT_MASK+1], entry_nx[14:12], entry_nx[7:0]};

  always_comb begin
    masked = entry_nx[BIT_MASK];
    level  = entry_nx[BIT_TRIG];
    ok     = !masked && !entry_nx[BIT_DSTM] &&
             (entry_nx[DLV_LSB +: DLV_W] == DLV_FIXED);
    rise   = irq && !lvl_q;
    replay = tbl_wr && pend_q && !masked;

    pend_d = pend_q;
    if (replay)                   pend_d = 1'b0;
    if (rise && masked && level)  pend_d = 1'b1;

    fire_d = (fire_q && !grant) || (rise && ok) || (replay && irq && ok);

    lvl_en  = (irq != lvl_q);
    pend_en = (pend_d != pend_q);
    fire_en = (fire_d != fire_q);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lvl_q <= 1'b0;
    end else if (lvl_en) begin
      lvl_q <= irq;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      fire_q <= 1'b0;
    end else if (fire_en) begin
      fire_q <= fire_d;
    end
  end
endmodule

// File: rtl/irq_redir_deliver.sv
module irq_redir_deliver
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned NCPU = 8
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic [NPIN-1:0]            fire_vec,
  input  logic [NPIN-1:0][ENT_W-1:0] tbl_q,
  input  logic [NCPU-1:0]            cpu_active,
  output logic [NPIN-1:0]            grant,
  output logic                       dlv_valid,
  output logic [VEC_W-1:0]           dlv_vector,
  output logic [NCPU-1:0]            dlv_dest
);
  logic [ENT_W-1:0] sel_e;
  logic [DID_W-1:0] did;
  logic [NCPU-1:0]  dest_d;
  logic             valid_d;
  logic             unused_bits;

  assign unused_bits = ^sel_e[DID_LSB-1:VEC_W];

  always_comb begin
    grant = fire_vec & (~fire_vec + NPIN'(1));
    sel_e = '0;
    for (int p = 0; p < NPIN; p++) begin
      if (grant[p]) sel_e = sel_e | tbl_q[p];
    end
    did    = sel_e[DID_LSB +: DID_W];
    dest_d = '0;
    if (did == DID_ALL) begin
      dest_d = cpu_active;
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        dest_d[c] = (did == DID_W'(c));
      end
    end
    valid_d = (|fire_vec) && (|dest_d);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dlv_valid <= 1'b0;
    end else begin
      dlv_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dlv_vector <= '0;
      dlv_dest   <= '0;
    end else if (valid_d) begin
      dlv_vector <= sel_e[VEC_W-1:0];
      dlv_dest   <= dest_d;
    end
  end
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned NCPU = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   irq_in,
  input  logic [NCPU-1:0]   cpu_active,
  output logic              dlv_valid,
  output logic [7:0]        dlv_vector,
  output logic [NCPU-1:0]   dlv_dest
);
  logic [1:0]                 rst_sync;
  logic                       arst_n;
  logic [WORD_W-1:0]          sel_q;
  logic [NPIN-1:0][ENT_W-1:0] tbl_q, tbl_nx;
  logic [NPIN-1:0]            tbl_wr, grant, fire_vec, pend_vec, lvl_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign arst_n = rst_sync[1];

  irq_redir_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .arst_n(arst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_q(sel_q), .tbl_q(tbl_q), .tbl_nx(tbl_nx), .tbl_wr(tbl_wr)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    irq_redir_pin u_pin (
      .clk(clk), .arst_n(arst_n), .irq(irq_in[p]),
      .entry_nx(tbl_nx[p]), .tbl_wr(tbl_wr[p]), .grant(grant[p]),
      .fire_q(fire_vec[p]), .pend_q(pend_vec[p]), .lvl_q(lvl_vec[p])
    );
  end

  irq_redir_deliver #(.NPIN(NPIN), .NCPU(NCPU)) u_dlv (
    .clk(clk), .arst_n(arst_n), .fire_vec(fire_vec), .tbl_q(tbl_q),
    .cpu_active(cpu_active), .grant(grant), .dlv_valid(dlv_valid),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest)
  );

  logic unused_lvl;
  assign unused_lvl = ^lvl_vec;
endmodule

// File: rtl/irq_redir_ctrl_chk.sv
module irq_redir_ctrl_chk #(
  parameter int unsigned NPIN = 16,
  parameter int unsigned NCPU = 8
) (
  input logic            clk,
  input logic            arst_n,
  input logic            bus_req,
  input logic            bus_we,
  input logic [7:0]      bus_addr,
  input logic [2:0]      bus_size,
  input logic [31:0]     bus_wdata,
  input logic [31:0]     bus_rdata,
  input logic [31:0]     sel_q,
  input logic [NPIN-1:0] irq_in,
  input logic [NCPU-1:0] cpu_active,
  input logic [NPIN-1:0] fire_vec,
  input logic [NPIN-1:0] pend_vec,
  input logic            dlv_valid,
  input logic [NCPU-1:0] dlv_dest
);
  localparam logic [31:0] VER_EXP = (32'(NPIN) << 16) | 32'h11;
  logic good_acc;
  assign good_acc = (bus_size == 3'd4) && ((bus_addr == 8'h00) || (bus_addr == 8'h10));

  assert_bad_rd_zero_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_req && !bus_we && !good_acc) |-> (bus_rdata == 32'h0));

  assert_bad_wr_ignored_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_req && bus_we && !good_acc) |=> $stable(sel_q));

  assert_sel_store_R2: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_req && bus_we && good_acc && bus_addr == 8'h00) |=> (sel_q == $past(bus_wdata)));

  assert_version_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (bus_req && !bus_we && good_acc && bus_addr == 8'h10 && sel_q[7:0] == 8'h01)
      |-> (bus_rdata == VER_EXP));

  assert_dlv_has_source_R6: assert property (@(posedge clk) disable iff (!arst_n)
    dlv_valid |-> $past(|fire_vec));

  assert_dest_shape_R7: assert property (@(posedge clk) disable iff (!arst_n)
    dlv_valid |-> ((dlv_dest != '0) &&
                   (($countones(dlv_dest) == 1) || ((dlv_dest & ~$past(cpu_active)) == '0))));

  assert_pend_needs_high_R9: assert property (@(posedge clk) disable iff (!arst_n)
    ((pend_vec & ~$past(pend_vec) & ~$past(irq_in)) == '0));
endmodule

bind irq_redir_ctrl irq_redir_ctrl_chk #(.NPIN(NPIN), .NCPU(NCPU)) u_chk (
  .clk(clk), .arst_n(arst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .sel_q(sel_q), .irq_in(irq_in),
  .cpu_active(cpu_active), .fire_vec(fire_vec), .pend_vec(pend_vec),
  .dlv_valid(dlv_valid), .dlv_dest(dlv_dest)
);

// File: tb/irq_redir_ctrl_bench.sv
module irq_redir_ctrl_bench;
  localparam int NPIN = 16;
  localparam int NCPU = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_req, bus_we;
  logic [7:0]      bus_addr;
  logic [2:0]      bus_size;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NPIN-1:0] irq_in;
  logic [NCPU-1:0] cpu_active;
  logic            dlv_valid;
  logic [7:0]      dlv_vector;
  logic [NCPU-1:0] dlv_dest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_redir_ctrl #(.NPIN(NPIN), .NCPU(NCPU)) u_irq_redir_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq_in), .cpu_active(cpu_active),
    .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest)
  );

  // {write, index, write data, expected read}
  localparam int NV = 10;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'hFF00_0000},  // R3 identity keeps 31:24
    {1'b1, 8'h01, 32'h1234_5678, 32'h0010_0011},  // R3 version read-only
    {1'b1, 8'h02, 32'h0000_0000, 32'hFF00_0000},  // R3 arbitration mirrors identity
    {1'b0, 8'h20, 32'h0,         32'h0001_0000},  // R5 reset low half
    {1'b0, 8'h2F, 32'h0,         32'h0001_0000},  // R5 reset high half
    {1'b1, 8'h12, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4 low half
    {1'b1, 8'h13, 32'hCAFE_0000, 32'hCAFE_0000},  // R4 high half
    {1'b0, 8'h12, 32'h0,         32'hDEAD_BEEF},  // R4 other half kept
    {1'b1, 8'h30, 32'h1111_1111, 32'h0000_0000},  // R4 beyond table
    {1'b0, 8'h05, 32'h0,         32'h0000_0000}   // R4 undefined index
  };

  task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [2:0] sz, logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [2:0] sz, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic set_sel(logic [7:0] i);
    bus_wr(8'h00, 3'd4, {24'h0, i});
  endtask

  task automatic win_wr(logic [31:0] d);
    bus_wr(8'h10, 3'd4, d);
  endtask

  task automatic win_rd_chk(string tag, logic [7:0] i, logic [31:0] exp);
    logic [31:0] d;
    set_sel(i);
    bus_rd(8'h10, 3'd4, d);
    chk32(tag, d, exp);
  endtask

  task automatic set_entry(int p, logic [31:0] hi, logic [31:0] lo);
    set_sel(8'(16 + 2 * p + 1));
    win_wr(hi);
    set_sel(8'(16 + 2 * p));
    win_wr(lo);
  endtask

  task automatic pin_drive(logic [NPIN-1:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic chk_dlv(string tag, logic ev, logic [7:0] evec, logic [NCPU-1:0] edst);
    @(negedge clk);
    chk32({tag, " valid"}, 32'(dlv_valid), 32'(ev));
    if (ev) begin
      chk32({tag, " vector"}, 32'(dlv_vector), 32'(evec));
      chk32({tag, " dest"}, 32'(dlv_dest), 32'(edst));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = '0;
    bus_wdata = '0; irq_in = '0; cpu_active = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 reset state
    chk32("R5 no delivery", 32'(dlv_valid), 32'h0);
    bus_rd(8'h00, 3'd4, d);
    chk32("R5 select", d, 32'h0);
    win_rd_chk("R5 identity", 8'h00, 32'h0);

    // register vectors: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        set_sel(VEC[i][71:64]);
        win_wr(VEC[i][63:32]);
      end
      win_rd_chk($sformatf("R3/R4/R5 vec%0d", i), VEC[i][71:64], VEC[i][31:0]);
    end

    // R2 select round trip, window uses bits 7:0
    bus_wr(8'h00, 3'd4, 32'h1234_5612);
    bus_rd(8'h00, 3'd4, d);
    chk32("R2 select readback", d, 32'h1234_5612);
    bus_rd(8'h10, 3'd4, d);
    chk32("R2 window low byte index", d, 32'hDEAD_BEEF);

    // R1 dishonoured accesses
    bus_rd(8'h04, 3'd4, d);
    chk32("R1 bad offset read", d, 32'h0);
    bus_rd(8'h10, 3'd2, d);
    chk32("R1 bad size read", d, 32'h0);
    bus_wr(8'h00, 3'd2, 32'h0000_0055);
    bus_wr(8'h08, 3'd4, 32'h0000_0066);
    bus_rd(8'h00, 3'd4, d);
    chk32("R1 ignored writes", d, 32'h1234_5612);
    bus_wr(8'h10, 3'd1, 32'h0);
    bus_rd(8'h10, 3'd4, d);
    chk32("R1 ignored window write", d, 32'hDEAD_BEEF);

    // R6 rising edge delivery
    set_entry(0, 32'h0100_0000, 32'h0000_0031);
    pin_drive(16'h0001);
    chk_dlv("R6 rise", 1'b1, 8'h31, 8'h02);
    chk_dlv("R6 single pulse", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0001);
    chk_dlv("R6 same level", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0000);
    chk_dlv("R6 fall", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0001);
    chk_dlv("R6 rise again", 1'b1, 8'h31, 8'h02);
    pin_drive(16'h0000);

    // R7 destinations
    cpu_active = 8'hA5;
    set_entry(2, 32'hFF00_0000, 32'h0000_0032);
    pin_drive(16'h0004);
    chk_dlv("R7 broadcast", 1'b1, 8'h32, 8'hA5);
    pin_drive(16'h0000);
    cpu_active = 8'h00;
    pin_drive(16'h0004);
    chk_dlv("R7 empty broadcast", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0000);
    cpu_active = 8'hFF;
    set_entry(4, 32'h0900_0000, 32'h0000_0034);
    pin_drive(16'h0010);
    chk_dlv("R7 id beyond cpus", 1'b0, 8'h0, 8'h0);
    set_entry(4, 32'h0700_0000, 32'h0000_0034);
    pin_drive(16'h0000);
    pin_drive(16'h0010);
    chk_dlv("R7 highest cpu", 1'b1, 8'h34, 8'h80);
    pin_drive(16'h0000);

    // R10 unsupported modes
    set_entry(5, 32'h0000_0000, 32'h0000_0135);
    pin_drive(16'h0020);
    chk_dlv("R10 non-fixed", 1'b0, 8'h0, 8'h0);
    set_entry(6, 32'h0000_0000, 32'h0000_0836);
    pin_drive(16'h0060);
    chk_dlv("R10 logical", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0000);

    // R8 masked edge dropped
    set_entry(7, 32'h0000_0000, 32'h0001_0037);
    pin_drive(16'h0080);
    chk_dlv("R8 masked edge", 1'b0, 8'h0, 8'h0);
    set_sel(8'h1E);
    win_wr(32'h0000_0037);
    chk_dlv("R8 unmask no replay", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0000);

    // R9 masked level pending and replay
    set_entry(8, 32'h0000_0000, 32'h0001_8038);
    pin_drive(16'h0100);
    chk_dlv("R9 masked level held", 1'b0, 8'h0, 8'h0);
    set_sel(8'h20);
    win_wr(32'h0000_8038);
    chk_dlv("R9 replay on unmask", 1'b1, 8'h38, 8'h01);
    win_wr(32'h0001_8038);
    win_wr(32'h0000_8038);
    chk_dlv("R9 pending cleared", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0000);
    set_entry(9, 32'h0000_0000, 32'h0001_8039);
    pin_drive(16'h0200);
    pin_drive(16'h0000);
    set_sel(8'h22);
    win_wr(32'h0000_8039);
    chk_dlv("R9 dropped when low", 1'b0, 8'h0, 8'h0);

    // R11 simultaneous rises
    set_entry(10, 32'h0000_0000, 32'h0000_003A);
    set_entry(11, 32'h0300_0000, 32'h0000_003B);
    pin_drive(16'h0C00);
    chk_dlv("R11 first lowest", 1'b1, 8'h3A, 8'h01);
    chk_dlv("R11 second", 1'b1, 8'h3B, 8'h08);
    chk_dlv("R11 then idle", 1'b0, 8'h0, 8'h0);
    pin_drive(16'h0000);

    // R12 write and rise in the same cycle
    set_sel(8'h17);
    win_wr(32'h0200_0000);
    set_sel(8'h16);
    irq_in = 16'h0008;
    win_wr(32'h0000_0044);
    chk_dlv("R12 updated entry used", 1'b1, 8'h44, 8'h04);
    pin_drive(16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule